// File: doc/BRIEF.md
# Buffered Program Command Sequencer

This block is the command front end of a NOR-style flash device for one job: programming up to 32 words in a single buffered operation. The host writes a setup command to an address in the target erase block. It then writes the word count minus one, followed by one address/data pair per word. A confirm command to the same block hands the filled buffer to a program engine. The engine stays busy for a fixed latency and then commits the buffered words to a behavioural array. That latency doubles when the range is unaligned and spills over a 32-word line.

The sequencer keeps a status byte. Bit 7 is ready. Bit 5 is the sequence fault. Bit 4 is the program error. Bit 3 flags low programming voltage. Each kind of failure leaves its own combination of these bits, and they stay set until the host issues a clear command. A single input tells the block whether the programming voltage is adequate. A second input lets a test force a program failure. The array can be read at any time through a separate read port.

Top module: `bufprog_seq`

## Requirements
- R1: After reset the status byte reads 0x80, and every array word reads 0xFFFF.
- R2: The full sequence commits each loaded word into the array and leaves unloaded words unchanged. The sequence is: command 0x00E8 written at an address in the target block, then a write whose low 5 bits are N-1, then N data writes whose address sets each word's location, then 0x00D0 written at an address in the same block (block = address bits [AW-1:7]). After the commit the status is 0x80.
- R3: Every data write after the first must have an address in the range from the start address to the start address plus N-1. A write outside that range aborts the sequence, sets bits 5 and 4 (status 0xB0) and programs nothing.
- R4: If the start address plus N-1 lies in a different 128-word erase block than the start address, the first data write aborts the sequence with status 0xB0, and nothing is programmed.
- R5: If the write in confirm position is not 0x00D0, or goes to another block, the status becomes 0xB0 and nothing is programmed.
- R6: If the programming-voltage input is low when the confirm arrives, the status becomes 0x98 and nothing is programmed.
- R7: If the fault input is high on the last busy cycle, nothing is written and the status becomes 0x90.
- R8: The engine stays busy for PGM_LAT cycles. It stays busy for 2*PGM_LAT cycles when start[4:0] plus N-1 exceeds 31.
- R9: Bit 7 of the status is 0 while the engine is busy. Every bus write during that time is ignored, including a clear command.
- R10: Bits 5, 4 and 3 stay set until command 0x0050 is written while idle, which returns the status to 0x80. Command 0x0070 changes nothing. A new sequence may start after any completion or abort.
- R11: Programming can only clear bits: the new array word is the AND of the old word and the buffered data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | AW | Host write word address |
| bus_wdata | input | DW | Host write data or command code |
| vpp_ok | input | 1 | High when the programming voltage is adequate |
| pgm_fail | input | 1 | Fault injection: the commit in progress fails |
| rd_addr | input | AW | Array read address |
| rd_data | output | DW | Array word at rd_addr |
| status | output | 8 | Status byte: ready, sequence fault, program error, low voltage |

## Verification
A vector table drives complete sequences. It includes a full aligned 32-word load, an unaligned load that stays inside one 32-word line, and an unaligned load that spills across a line. The latency each of these produces tells the single-time case from the doubled-time case. Further rows break one rule each: an erase-block crossing, a stray address, a wrong confirm, low voltage, and an injected fault. The status code and the unchanged array contents of each row show that every failure is detected separately. A second load to an already programmed word shows the AND behaviour. Directed tests cover reset values, the read-status no-op, the clear command, and writes arriving during a busy period.

// File: rtl/bufprog_seq.sv
module bufprog_seq #(
  parameter int AW          = 10,
  parameter int DW          = 16,
  parameter int BUF_WORDS   = 32,
  parameter int BLOCK_WORDS = 128,
  parameter int PGM_LAT     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          vpp_ok,
  input  logic          pgm_fail,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    status
);
  localparam int BW    = $clog2(BUF_WORDS);
  localparam int BLKW  = $clog2(BLOCK_WORDS);
  localparam int CW    = $clog2(2*PGM_LAT+1);
  localparam int DEPTH = 2**AW;

  typedef enum logic [2:0] {S_IDLE, S_CNT, S_DATA, S_CONF, S_BUSY} st_t;

  st_t                 state;
  logic [AW-BLKW-1:0]  setup_blk;
  logic [BW-1:0]       cnt, wr_n;
  logic [AW-1:0]       start;
  logic [CW-1:0]       busy_cnt;
  logic                sr5, sr4, sr3;
  logic [DW-1:0]       buf_d [BUF_WORDS];
  logic [BUF_WORDS-1:0] buf_v;
  logic [DW-1:0]       mem [DEPTH];

  wire is_setup = bus_wdata == DW'(16'h00E8);
  wire is_conf  = bus_wdata == DW'(16'h00D0);
  wire is_clr   = bus_wdata == DW'(16'h0050);
  wire busy     = state == S_BUSY;
  wire first    = wr_n == '0;
  wire clr_hit  = state == S_IDLE && bus_we && is_clr;

  wire [AW:0] off = {1'b0, bus_addr} - {1'b0, start};
  wire out_win = off[AW] || (off[AW-1:0] > AW'(cnt));
  wire cross_blk = ((({1'b0, bus_addr} + (AW+1)'(cnt)) >> BLKW) != ({1'b0, bus_addr} >> BLKW));
  wire cross32 = ({1'b0, start[BW-1:0]} + {1'b0, cnt}) > (BW+1)'(BUF_WORDS-1);
  wire [BW-1:0] slot = first ? '0 : off[BW-1:0];
  wire conf_ok = is_conf && (bus_addr[AW-1:BLKW] == setup_blk);

  assign status  = {~busy, 1'b0, sr5, sr4, sr3, 3'b000};
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      setup_blk <= '0;
      cnt       <= '0;
      wr_n      <= '0;
      start     <= '0;
      busy_cnt  <= '0;
      sr5       <= 1'b0;
      sr4       <= 1'b0;
      sr3       <= 1'b0;
      buf_v     <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      case (state)
        S_IDLE: if (bus_we) begin
          if (is_setup) begin
            state     <= S_CNT;
            setup_blk <= bus_addr[AW-1:BLKW];
            buf_v     <= '0;
          end else if (is_clr) begin
            sr5 <= 1'b0;
            sr4 <= 1'b0;
            sr3 <= 1'b0;
          end
        end
        S_CNT: if (bus_we) begin
          cnt   <= bus_wdata[BW-1:0];
          wr_n  <= '0;
          state <= S_DATA;
        end
        S_DATA: if (bus_we) begin
          if (first ? cross_blk : out_win) begin
            sr5   <= 1'b1;
            sr4   <= 1'b1;
            state <= S_IDLE;
          end else begin
            if (first) start <= bus_addr;
            buf_d[slot] <= bus_wdata;
            buf_v[slot] <= 1'b1;
            wr_n        <= wr_n + 1'b1;
            if (wr_n == cnt) state <= S_CONF;
          end
        end
        S_CONF: if (bus_we) begin
          if (!conf_ok) begin
            sr5   <= 1'b1;
            sr4   <= 1'b1;
            state <= S_IDLE;
          end else if (!vpp_ok) begin
            sr4   <= 1'b1;
            sr3   <= 1'b1;
            state <= S_IDLE;
          end else begin
            busy_cnt <= cross32 ? CW'(2*PGM_LAT) : CW'(PGM_LAT);
            state    <= S_BUSY;
          end
        end
        S_BUSY: begin
          if (busy_cnt == CW'(1)) begin
            state <= S_IDLE;
            if (pgm_fail) sr4 <= 1'b1;
            else
              for (int i = 0; i < BUF_WORDS; i++)
                if (buf_v[i]) mem[start + AW'(i)] <= mem[start + AW'(i)] & buf_d[i];
          end
          busy_cnt <= busy_cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: busy period starts with one of the two legal lengths
  a_r8_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (busy_cnt == CW'(PGM_LAT) || busy_cnt == CW'(2*PGM_LAT)));

  // R6: the engine never starts without adequate voltage at confirm
  a_r6_vpp_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(vpp_ok));

  // R10: error bits fall only after an accepted clear command
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sr5) || $fell(sr4) || $fell(sr3)) |-> $past(clr_hit));

  // R9: writes during busy leave fault bits and setup state untouched
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(sr5) && $stable(sr3) && $stable(setup_blk)));

  // R4: an erase-block crossing at the first data write aborts with a sequence fault
  a_r4_blk_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA && bus_we && first && cross_blk) |=> (sr5 && sr4 && state == S_IDLE));
endmodule

// File: tb/bufprog_seq_tb.sv
module bufprog_seq_tb;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int LAT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic vpp_ok = 1'b1;
  logic pgm_fail = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [2**AW];

  always #2.5 clk = ~clk;

  bufprog_seq #(.AW(AW), .DW(DW), .BUF_WORDS(32), .BLOCK_WORDS(128), .PGM_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .vpp_ok(vpp_ok), .pgm_fail(pgm_fail), .rd_addr(rd_addr), .rd_data(rd_data), .status(status));

  // fields: start[31:20], cnt[19:12], mode[11:8], expected status[7:0]
  // mode 0 clean, 1 stray address, 2 bad confirm, 3 low voltage, 4 injected fault
  localparam logic [31:0] VEC [9] = '{
    {12'h000, 8'd31, 4'd0, 8'h80},
    {12'h045, 8'd9,  4'd0, 8'h80},
    {12'h05C, 8'd7,  4'd0, 8'h80},
    {12'h0FC, 8'd7,  4'd0, 8'hB0},
    {12'h100, 8'd3,  4'd1, 8'hB0},
    {12'h120, 8'd3,  4'd2, 8'hB0},
    {12'h140, 8'd3,  4'd3, 8'h98},
    {12'h160, 8'd3,  4'd4, 8'h90},
    {12'h000, 8'd0,  4'd0, 8'h80}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int v, input int i);
    return 16'hFFFF ^ (16'h1 << v) ^ 16'(i << 4);
  endfunction

  task automatic run_seq(input int v, input logic [AW-1:0] st, input int n1, input int mode);
    vpp_ok = (mode != 3);
    pgm_fail = (mode == 4);
    wr(st, 16'h00E8);
    wr(st, 16'(n1));
    for (int i = 0; i <= n1; i++) begin
      logic [AW-1:0] a;
      a = st + AW'(i);
      if (mode == 1 && i == n1) a = st + AW'(n1 + 1);
      wr(a, pat(v, i));
    end
    wr(st, (mode == 2) ? 16'h00FF : 16'h00D0);
  endtask

  task automatic wait_ready(output int cyc);
    cyc = 0;
    while (status[7] == 1'b0 && cyc < 100) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic check_words(input string req, input logic [AW-1:0] st, input int n);
    for (int i = 0; i <= n; i++) begin
      rd_addr = st + AW'(i);
      #1;
      chk(req, rd_data, model[st + AW'(i)]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    for (int i = 0; i < 2**AW; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", 16'(status), 16'h0080);
    rd_addr = 10'h005; #1;
    chk("R1 array", rd_data, 16'hFFFF);
    rd_addr = 10'h3FF; #1;
    chk("R1 array", rd_data, 16'hFFFF);

    for (int v = 0; v < 9; v++) begin
      logic [AW-1:0] st;
      int n1, mode, exp_lat;
      logic [7:0] exp_st;
      st = VEC[v][29:20];
      n1 = int'(VEC[v][19:12]);
      mode = int'(VEC[v][11:8]);
      exp_st = VEC[v][7:0];
      run_seq(v, st, n1, mode);
      if (mode == 0 && exp_st == 8'h80)
        exp_lat = (int'(st[4:0]) + n1 > 31) ? 2*LAT : LAT;
      else if (mode == 4)
        exp_lat = LAT;
      else
        exp_lat = 0;
      wait_ready(cyc);
      chk("R8 busy length", 16'(cyc), 16'(exp_lat));
      chk((exp_st == 8'h80) ? "R2 status" : (mode == 0) ? "R4 status" : (mode == 1) ? "R3 status" :
          (mode == 2) ? "R5 status" : (mode == 3) ? "R6 status" : "R7 status", 16'(status), 16'(exp_st));
      if (exp_st == 8'h80)
        for (int i = 0; i <= n1; i++) model[st + AW'(i)] = model[st + AW'(i)] & pat(v, i);
      check_words((v == 8) ? "R11 and-merge" : (exp_st == 8'h80) ? "R2 array" : "R3-R7 array untouched",
                  st, n1 + 1);
      if (status != 8'h80) begin
        wr(10'h000, 16'h0070);
        chk("R10 read-status no-op", 16'(status), 16'(exp_st));
        wr(10'h000, 16'h0050);
        chk("R10 clear", 16'(status), 16'h0080);
      end
    end
    rd_addr = 10'h000; #1;
    chk("R11 and-merge value", rd_data, 16'hFEFE);

    // R9: writes during busy are ignored, sticky bits survive a later success
    run_seq(2, 10'h200, 1, 3);
    chk("R6 sticky", 16'(status), 16'h0098);
    run_seq(3, 10'h200, 1, 0);
    chk("R9 busy flag", 16'(status[7]), 16'h0000);
    wr(10'h200, 16'h0050);
    wr(10'h200, 16'h00E8);
    chk("R9 still busy", 16'(status[7]), 16'h0000);
    wait_ready(cyc);
    chk("R9 clear ignored while busy", 16'(status), 16'h0098);
    model[10'h200] = model[10'h200] & pat(3, 0);
    model[10'h201] = model[10'h201] & pat(3, 1);
    check_words("R9 program completed", 10'h200, 2);
    wr(10'h000, 16'h0050);
    chk("R10 clear after busy", 16'(status), 16'h0080);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule